// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a clocked static RAM whose data word is split into byte lanes. Every address, data and control input is registered on the rising clock edge. Read data then passes through a second, output register before it reaches the pins. An access sequence starts when one of two active-low start strobes is sampled low while the chip is selected. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, according to the write controls sampled in the same cycle. After a start, a 2-bit beat counter steps through the other three words of an aligned group of four. It steps only in cycles where the active-low advance input is low. The order of the steps is linear or interleaved, chosen by `order_sel`.

Writes can update any subset of lanes through a lane gate plus per-lane strobes, or all lanes through a single all-lanes write input. Output drive is reported on `dq_drive`, and the written data enters on a separate `wdata` port. After the last read beat, the outputs stay driven for one more cycle and hold the last word, then they are released. `oe_n` masks the drive combinationally and does not alter the pipeline. Every port has a plain, fixed per-cycle meaning, so there is no valid/ready handshake and no back-pressure: one access per clock is always accepted.

Top module: `burst_sram`

## Requirements
- R1: Read latency is two edges. A read sampled at edge k shows its word on `rdata` after edge k+1. A write sampled at edge k is visible to a read sampled at edge k+1.
- R2: `start_p_n` low while selected loads `addr` and performs a read whatever the write controls are. When both strobes are low, the processor-side strobe wins and the cycle is a read.
- R3: `start_c_n` low (with `start_p_n` high) while selected loads `addr` and performs the access that the write controls select.
- R4: In a cycle with both strobes high during an active sequence, the beat counter steps when `adv_n` is low and holds when `adv_n` is high. A held cycle accesses the same word again.
- R5: With `order_sel` = 0, beat n accesses the address whose bits [1:0] are (start[1:0] + n) mod 4, while the upper bits keep their start value. The order wraps after four beats.
- R6: With `order_sel` = 1, beat n accesses the address whose bits [1:0] are start[1:0] XOR n, while the upper bits keep their start value.
- R7: With `all_wr_n` high and `lane_gate_n` low, lane i (bits [8i+7:8i]) is written when `lane_wr_n[i]` is low, and the other lanes keep their contents. If no lane strobe is low, or if `lane_gate_n` is high, the cycle is a read.
- R8: `all_wr_n` low writes every lane, whatever `lane_gate_n` and `lane_wr_n` are.
- R9: The chip is selected only when `ce_a_n` = 0, `ce_b` = 1 and `ce_c_n` = 0, sampled with a strobe. A strobe while not selected ends the sequence with no access. Later cycles without a strobe then access and write nothing until a selected start.
- R10: `dq_drive` is high after each read beat and for exactly one further cycle after the last beat of a read run. During that extra cycle `rdata` holds the last word. Otherwise `dq_drive` is low.
- R11: `oe_n` high forces `dq_drive` low in the same cycle, and it leaves the read pipeline and `rdata` unaffected.
- R12: During and right after reset, no sequence is active and `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Start address, sampled with a strobe |
| start_p_n | input | 1 | Processor-side start strobe, active low, always a read |
| start_c_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| order_sel | input | 1 | 0 linear, 1 interleaved beat order |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_gate_n | input | 1 | Enables per-lane write strobes, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, combinational |
| rdata | output | LANES*LANE_W | Output pipeline register |
| dq_drive | output | 1 | High when the outputs would be driven |

## Verification
The assertions assume that `order_sel` stays constant within a sequence, since the step checks compare consecutive addresses under one order. They also assume that the chip enables are meaningful only in cycles carrying a strobe. The stimulus changes `order_sel` and the enables only in cycles that start or end a sequence. It changes every input once per cycle, well away from the sampling edge. It reads back only words it has written earlier, so every compared value is defined.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p_n,
  input  logic              start_c_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              selected,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              access,
  output logic              from_proc,
  output logic              active,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              strobe, load;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [BEAT_W-1:0] cnt_q, cnt_n, low_mix;

  assign strobe = ~start_p_n | ~start_c_n;
  assign load   = strobe & selected;

  always_comb begin
    base_n = load ? addr_in : base_q;
    if (load)
      cnt_n = '0;
    else if (active & ~adv_n)
      cnt_n = cnt_q + 1'b1;
    else
      cnt_n = cnt_q;
    low_mix  = order_sel ? (base_n[BEAT_W-1:0] ^ cnt_n)
                         : (base_n[BEAT_W-1:0] + cnt_n);
    eff_addr = {base_n[ADDR_W-1:BEAT_W], low_mix};
  end

  assign access    = load | (~strobe & active);
  assign from_proc = load & ~start_p_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (strobe) active <= selected;
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/lane_write_decode.sv
module lane_write_decode #(
  parameter int LANES = 4
) (
  input  logic             allow,
  input  logic             all_wr_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = allow & (~all_wr_n | (~lane_gate_n & ~lane_wr_n[g]));
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_mask[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
  end

  assign rd_word = mem[addr];
endmodule

// File: rtl/read_out_pipe.sv
module read_out_pipe #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  input  logic              oe_n,
  output logic [WORD_W-1:0] q,
  output logic              rd_q,
  output logic              hold_q,
  output logic              drive
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      rd_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (load) q <= d;
      rd_q   <= load;
      hold_q <= rd_q & ~load;
    end
  end

  assign drive = (rd_q | hold_q) & ~oe_n;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    start_p_n,
  input  logic                    start_c_n,
  input  logic                    adv_n,
  input  logic                    order_sel,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    all_wr_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    dq_drive
);
  localparam int WORD_W = LANES * LANE_W;

  logic              selected, access, from_proc, active;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  mask_n;
  acc_kind_e         kind_n, s1_kind;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s1_wdata, rd_word;
  logic [LANES-1:0]  s1_mask;
  logic              s1_rd, rd_q, hold_q;

  assign selected = ~ce_a_n & ce_b & ~ce_c_n;

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk(clk), .rst_n(rst_n), .start_p_n(start_p_n), .start_c_n(start_c_n),
    .adv_n(adv_n), .order_sel(order_sel), .selected(selected), .addr_in(addr),
    .access(access), .from_proc(from_proc), .active(active), .eff_addr(eff_addr)
  );

  lane_write_decode #(.LANES(LANES)) i_dec (
    .allow(access & ~from_proc), .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n),
    .lane_wr_n(lane_wr_n), .mask(mask_n)
  );

  always_comb begin
    if (!access)     kind_n = ACC_NONE;
    else if (|mask_n) kind_n = ACC_WRITE;
    else             kind_n = ACC_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_kind  <= ACC_NONE;
      s1_addr  <= '0;
      s1_wdata <= '0;
      s1_mask  <= '0;
    end else begin
      s1_kind  <= kind_n;
      s1_addr  <= eff_addr;
      s1_wdata <= wdata;
      s1_mask  <= mask_n;
    end
  end

  assign s1_rd = (s1_kind == ACC_READ);

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_mem (
    .clk(clk), .wr_mask(s1_mask), .addr(s1_addr), .wdata(s1_wdata), .rd_word(rd_word)
  );

  read_out_pipe #(.WORD_W(WORD_W)) i_out (
    .clk(clk), .rst_n(rst_n), .load(s1_rd), .d(rd_word), .oe_n(oe_n),
    .q(rdata), .rd_q(rd_q), .hold_q(hold_q), .drive(dq_drive)
  );
endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_p_n,
  input logic              start_c_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              all_wr_n,
  input logic              access,
  input logic              from_proc,
  input logic              active,
  input acc_kind_e         s1_kind,
  input logic [ADDR_W-1:0] s1_addr,
  input logic [LANES-1:0]  s1_mask,
  input logic              s1_rd,
  input logic              rd_q,
  input logic              hold_q,
  input logic [WORD_W-1:0] rdata
);
  logic strobe, sel;
  assign strobe = ~start_p_n | ~start_c_n;
  assign sel    = ~ce_a_n & ce_b & ~ce_c_n;

  a_r2_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_p_n && sel) |=> (s1_kind == ACC_READ && s1_mask == '0));

  a_r8_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !from_proc && !all_wr_n) |=> (&s1_mask));

  a_r9_desel_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sel) |=> (s1_kind == ACC_NONE));

  a_r9_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !active) |=> (s1_kind == ACC_NONE));

  a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && active && adv_n) |=> $stable(s1_addr));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && active && !adv_n && !order_sel) |=>
      (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1 &&
       s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  a_r6_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && active && !adv_n && order_sel) |=>
      (s1_addr[1:0] != $past(s1_addr[1:0]) &&
       s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  a_r10_hold_once: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> !hold_q);

  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !s1_rd) |=> $stable(rdata));
endmodule

bind burst_sram burst_sram_checker #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_p_n(start_p_n), .start_c_n(start_c_n),
  .adv_n(adv_n), .order_sel(order_sel), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
  .all_wr_n(all_wr_n), .access(access), .from_proc(from_proc), .active(active),
  .s1_kind(s1_kind), .s1_addr(s1_addr), .s1_mask(s1_mask), .s1_rd(s1_rd),
  .rd_q(rd_q), .hold_q(hold_q), .rdata(rdata)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        start_p_n = 1'b1, start_c_n = 1'b1, adv_n = 1'b1, order_sel = 1'b0;
  logic        ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic        all_wr_n = 1'b1, lane_gate_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [31:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic [31:0] rdata;
  logic        dq_drive;

  logic nxt_cea_n = 1'b0, nxt_ceb = 1'b1, nxt_cec_n = 1'b0, nxt_oe_n = 1'b0, nxt_mode = 1'b0;

  always #10 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .start_p_n(start_p_n), .start_c_n(start_c_n),
    .adv_n(adv_n), .order_sel(order_sel), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n), .wdata(wdata),
    .oe_n(oe_n), .rdata(rdata), .dq_drive(dq_drive)
  );

  typedef struct {
    int          due;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t       sb[$];
  logic [31:0] mem_m [64];
  int          cyc = 0;
  int          checks = 0, fails = 0;
  int          last_due = -10;
  logic [31:0] last_data = '0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // kind: 0 no access, 1 read, 2 write
  task automatic step(input logic p_n, input logic c_n, input logic a_n, input logic g_n,
                      input logic be_n, input logic [3:0] l_n, input logic [5:0] ad,
                      input logic [31:0] wd, input int kind, input logic [5:0] ea, input string req);
    logic [3:0] m;
    @(posedge clk); #1;
    start_p_n = p_n; start_c_n = c_n; adv_n = a_n; all_wr_n = g_n;
    lane_gate_n = be_n; lane_wr_n = l_n; addr = ad; wdata = wd;
    ce_a_n = nxt_cea_n; ce_b = nxt_ceb; ce_c_n = nxt_cec_n; oe_n = nxt_oe_n; order_sel = nxt_mode;
    if (kind == 1) sb.push_back('{cyc + 2, mem_m[ea], req});
    if (kind == 2) begin
      m = !g_n ? 4'hF : (!be_n ? ~l_n : 4'h0);
      for (int i = 0; i < 4; i++)
        if (m[i]) mem_m[ea][i*8 +: 8] = wd[i*8 +: 8];
    end
  endtask

  task automatic rd_p(input logic [5:0] ad, input string req);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ad, 32'h0, 1, ad, req);
  endtask

  task automatic rd_c(input logic [5:0] ad, input string req);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, ad, 32'h0, 1, ad, req);
  endtask

  task automatic cont_rd(input logic a_n, input logic [5:0] ea, input string req);
    step(1'b1, 1'b1, a_n, 1'b1, 1'b1, 4'hF, 6'h0, 32'h0, 1, ea, req);
  endtask

  task automatic desel();
    nxt_ceb = 1'b0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h0, 32'h0, 0, 6'h0, "R9");
    nxt_ceb = 1'b1;
  endtask

  function automatic logic [31:0] pat(input logic [5:0] a);
    return {8'h10 + 8'(a), 8'h20 + 8'(a), 8'h30 + 8'(a), 8'h40 + 8'(a)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit got;
      bit exp_drv;
      got = 1'b0;
      if (sb.size() > 0 && sb[0].due < cyc) begin
        item_t lost;
        lost = sb.pop_front();
        check(1'b0, {lost.req, " missed read"}, rdata, lost.data);
      end
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check(rdata === it.data, {it.req, " R1 read data"}, rdata, it.data);
        last_data = it.data;
        last_due  = cyc;
        got = 1'b1;
      end
      if (!got && last_due == cyc - 1)
        check(rdata === last_data, "R10 held word", rdata, last_data);
      exp_drv = !oe_n && (got || last_due == cyc - 1);
      check(dq_drive === exp_drv, oe_n ? "R11 drive masked" : "R10 drive window",
            {31'h0, dq_drive}, {31'h0, exp_drv});
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    #5;
    check(dq_drive === 1'b0, "R12 drive low in reset", {31'h0, dq_drive}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_drive === 1'b0, "R12 drive low after reset", {31'h0, dq_drive}, 32'h0);

    // fill 0x10..0x1F with linear all-lane bursts (R3, R5, R8)
    for (int b = 0; b < 4; b++) begin
      logic [5:0] base;
      base = 6'(16 + 4 * b);
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, base, pat(base), 2, base, "R3");
      for (int n = 1; n < 4; n++)
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'h0, pat(base + 6'(n)), 2, base + 6'(n), "R5");
    end
    desel();

    // linear read burst from 0x16 with wrap (R2, R5)
    rd_p(6'h16, "R2");
    cont_rd(1'b0, 6'h17, "R5");
    cont_rd(1'b0, 6'h14, "R5");
    cont_rd(1'b0, 6'h15, "R5");
    desel();
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h0, 32'h0, 0, 6'h0, "R9");

    // interleaved burst from 0x1A (R3, R6)
    nxt_mode = 1'b1;
    rd_c(6'h1A, "R3");
    cont_rd(1'b0, 6'h1B, "R6");
    cont_rd(1'b0, 6'h18, "R6");
    cont_rd(1'b0, 6'h19, "R6");
    desel();

    // hold then advance, interleaved from 0x1D (R4, R6)
    rd_p(6'h1D, "R4");
    cont_rd(1'b1, 6'h1D, "R4");
    cont_rd(1'b0, 6'h1C, "R6");
    cont_rd(1'b0, 6'h1F, "R6");
    desel();
    nxt_mode = 1'b0;

    // lane writes: lanes 0 and 2 only (R7)
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010, 6'h12, 32'hAABBCCDD, 2, 6'h12, "R7");
    desel();
    rd_p(6'h12, "R7");
    desel();
    // gate low, no lane strobe: a read (R7)
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h13, 32'hFFFFFFFF, 1, 6'h13, "R7");
    desel();

    // all-lanes write overrides lane controls (R8)
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 6'h14, 32'h11223344, 2, 6'h14, "R8");
    desel();
    rd_p(6'h14, "R8");
    desel();

    // processor strobe ignores write controls; wins over controller strobe (R2)
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 6'h15, 32'hDEADBEEF, 1, 6'h15, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h16, 32'hDEADBEEF, 1, 6'h16, "R2");
    desel();
    rd_p(6'h15, "R2");
    desel();

    // continue cycles while deselected write nothing (R9)
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'h0, 32'hBAD0BAD0, 0, 6'h0, "R9");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'h0, 32'hBAD1BAD1, 0, 6'h0, "R9");
    rd_p(6'h16, "R9");
    cont_rd(1'b0, 6'h17, "R9");
    desel();

    // one enable inactive blocks a start (R9)
    nxt_cea_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h11, 32'h0BAD0BAD, 0, 6'h0, "R9");
    nxt_cea_n = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'h0, 32'h0BAD0BAD, 0, 6'h0, "R9");
    nxt_cec_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h11, 32'h0BAD0BAD, 0, 6'h0, "R9");
    nxt_cec_n = 1'b0;
    rd_p(6'h11, "R9");
    desel();

    // output enable masks drive only (R11)
    nxt_oe_n = 1'b1;
    rd_p(6'h10, "R11");
    cont_rd(1'b0, 6'h11, "R11");
    cont_rd(1'b0, 6'h12, "R11");
    nxt_oe_n = 1'b0;
    cont_rd(1'b0, 6'h13, "R11");
    desel();

    // write then immediate read of same word (R1)
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h18, 32'h5A5A0F0F, 2, 6'h18, "R1");
    rd_c(6'h18, "R1");
    desel();

    repeat (5) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h0, 32'h0, 0, 6'h0, "R10");
    @(negedge clk);
    check(sb.size() == 0, "R1 all reads returned", 32'(sb.size()), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule